// File: doc/BRIEF.md
# Keyed Write Gate for a Slow-Clock Register Block

This block sits between a fast host register port and a peripheral whose registers live in a slow clock domain. A host may only change a peripheral register after it has armed the gate by writing a 16-bit key to a dedicated unlock address. Each arming is good for exactly one protected write. After a protected write is forwarded, the gate reports "not ready" until the write has had time to cross into the slow domain. That time is measured in slow-clock ticks, which arrive as one-cycle strobes on `slow_tick`.

Software follows a fixed order. It waits until the ready bit in the control word is high, writes the key, polls the enable bit of the unlock word, waits for ready again, and then writes the target register. A protected write made while the gate is locked or busy is thrown away and raises a sticky error flag. Unlock-address writes are always taken and are never passed to the peripheral. Host writes are plain one-cycle strobes with no back-pressure: the only way the gate refuses a write is by dropping it, because that is its function. Reads are combinational, and for every address except the unlock word they pass the peripheral's data through.

Top module: `keyed_wr_gate`

## Requirements
- R1: After reset, the enable status is 0, ready is 1, the error flag is 0 and `per_we` is 0.
- R2: A write to the unlock address (0x3C) whose whole 32-bit value equals 0x0000A55A sets the enable status from the next cycle on. It reads as bit 31 of the unlock word and on `wr_en_o`.
- R3: A write to the unlock address with any other value, including 0x0001A55A, clears the enable status from the next cycle on.
- R4: A write to any other address while enabled and ready is forwarded. `per_we` is high for exactly the one cycle after the host strobe, carrying the host's address and data.
- R5: Forwarding a write clears the enable status in the same cycle that `per_we` is high, so every protected write needs a fresh key.
- R6: From the cycle after a forwarded write, ready (`wr_rdy_o` and bit 7 of the control word at 0x00) is 0. It returns to 1 in the cycle after the third `slow_tick` strobe counted after that write.
- R7: A protected write while locked is dropped: no `per_we`, and the error flag (bit 0 of the unlock word, `err_o`) is 1 from the next cycle.
- R8: A protected write while enabled but not ready is dropped and sets the error flag, and the enable status stays set.
- R9: An unlock-address write is taken while ready is 0 and never produces `per_we`.
- R10: Reads are combinational. Address 0x00 returns `per_rdata` with bit 7 replaced by ready. Address 0x3C returns enable status in bit 31, the error flag in bit 0 and zeros elsewhere. Any other address returns `per_rdata` unchanged.
- R11: The error flag stays set until reset, whatever is written afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe per slow-domain clock edge |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host write address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 8 | Host read address |
| host_rdata | output | 32 | Host read data |
| per_rdata | input | 32 | Read data from the peripheral |
| per_raddr | output | 8 | Read address passed to the peripheral |
| per_we | output | 1 | Forwarded write strobe to the peripheral |
| per_addr | output | 8 | Forwarded write address |
| per_wdata | output | 32 | Forwarded write data |
| wr_en_o | output | 1 | Enable status (key accepted, write pending) |
| wr_rdy_o | output | 1 | Ready status (no transfer in flight) |
| err_o | output | 1 | Sticky dropped-write flag |

## Verification
Every registered result (enable status, error flag, `per_we` with its address and data, and the fall of ready) is due one clock after the host strobe. The bench drives at a falling edge and checks at the very next falling edge. The `per_we` pulse is checked again one cycle later to confirm it has ended. The return of ready is due one cycle after the third counted tick, so the bench applies a set number of tick strobes and samples ready at the falling edge that follows the last one. Reads are checked in the same cycle that the read address is applied.

// File: rtl/kwg_pkg.sv
package kwg_pkg;
  typedef struct packed {
    logic key_wr;
    logic fwd;
    logic drop;
  } wr_decision_t;
endpackage

// File: rtl/kwg_key_lock.sv
module kwg_key_lock #(
  parameter int DATA_W = 32,
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hA55A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              consume,
  output logic              enabled
);
  localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(KEY);

  logic key_match;
  assign key_match = (wdata == KEY_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n)       enabled <= 1'b0;
    else if (key_wr)  enabled <= key_match;
    else if (consume) enabled <= 1'b0;
  end
endmodule

// File: rtl/kwg_xfer_busy.sv
module kwg_xfer_busy #(
  parameter int BUSY_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic slow_tick,
  output logic ready
);
  generate
    if (BUSY_TICKS == 0) begin : g_none
      assign ready = 1'b1;
    end else begin : g_cnt
      localparam int CNT_W = $clog2(BUSY_TICKS + 1);
      logic [CNT_W-1:0] left;
      always_ff @(posedge clk) begin
        if (!rst_n)                         left <= '0;
        else if (start)                     left <= CNT_W'(BUSY_TICKS);
        else if (slow_tick && left != '0)   left <= left - 1'b1;
      end
      assign ready = (left == '0);
    end
  endgenerate
endmodule

// File: rtl/kwg_read_mux.sv
module kwg_read_mux #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 8'h3C,
  parameter int RDY_BIT = 7,
  parameter int EN_BIT = 31,
  parameter int ERR_BIT = 0
) (
  input  logic [ADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0] per_rdata,
  input  logic              enabled,
  input  logic              ready,
  input  logic              err,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = per_rdata;
    if (raddr == CTRL_ADDR) begin
      rdata[RDY_BIT] = ready;
    end else if (raddr == UNLOCK_ADDR) begin
      rdata = '0;
      rdata[EN_BIT] = enabled;
      rdata[ERR_BIT] = err;
    end
  end
endmodule

// File: rtl/keyed_wr_gate.sv
module keyed_wr_gate
  import kwg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hA55A,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 8'h3C,
  parameter int BUSY_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] per_rdata,
  output logic [ADDR_W-1:0] per_raddr,
  output logic              per_we,
  output logic [ADDR_W-1:0] per_addr,
  output logic [DATA_W-1:0] per_wdata,
  output logic              wr_en_o,
  output logic              wr_rdy_o,
  output logic              err_o
);
  wr_decision_t dec;
  logic enabled, ready, err_q;

  always_comb begin
    dec = '0;
    if (host_we) begin
      if (host_addr == UNLOCK_ADDR)  dec.key_wr = 1'b1;
      else if (enabled && ready)     dec.fwd = 1'b1;
      else                           dec.drop = 1'b1;
    end
  end

  kwg_key_lock #(.DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY)) u_lock (
    .clk(clk), .rst_n(rst_n), .key_wr(dec.key_wr), .wdata(host_wdata),
    .consume(dec.fwd), .enabled(enabled)
  );

  kwg_xfer_busy #(.BUSY_TICKS(BUSY_TICKS)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(dec.fwd), .slow_tick(slow_tick),
    .ready(ready)
  );

  kwg_read_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .UNLOCK_ADDR(UNLOCK_ADDR), .RDY_BIT(7), .EN_BIT(DATA_W-1), .ERR_BIT(0)
  ) u_rmux (
    .raddr(host_raddr), .per_rdata(per_rdata), .enabled(enabled),
    .ready(ready), .err(err_q), .rdata(host_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (dec.drop) err_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_we    <= 1'b0;
      per_addr  <= '0;
      per_wdata <= '0;
    end else begin
      per_we <= dec.fwd;
      if (dec.fwd) begin
        per_addr  <= host_addr;
        per_wdata <= host_wdata;
      end
    end
  end

  assign per_raddr = host_raddr;
  assign wr_en_o   = enabled;
  assign wr_rdy_o  = ready;
  assign err_o     = err_q;
endmodule

// File: rtl/kwg_checker.sv
module kwg_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 8'h3C,
  parameter logic [DATA_W-1:0] KEY_WORD = 32'h0000A55A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              per_we,
  input logic [ADDR_W-1:0] per_addr,
  input logic              wr_en_o,
  input logic              wr_rdy_o,
  input logic              err_o
);
  a_r2_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == UNLOCK_ADDR && host_wdata == KEY_WORD) |=> wr_en_o);

  a_r3_bad_key_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == UNLOCK_ADDR && host_wdata != KEY_WORD) |=> !wr_en_o);

  a_r4_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr != UNLOCK_ADDR && wr_en_o && wr_rdy_o)
      |=> (per_we && per_addr == $past(host_addr)));

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    per_we |=> !per_we);

  a_r5_relock: assert property (@(posedge clk) disable iff (!rst_n)
    per_we |-> !wr_en_o);

  a_r6_busy_after_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    per_we |-> !wr_rdy_o);

  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr != UNLOCK_ADDR && !(wr_en_o && wr_rdy_o))
      |=> (!per_we && err_o));

  a_r8_keep_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr != UNLOCK_ADDR && wr_en_o && !wr_rdy_o) |=> wr_en_o);

  a_r9_unlock_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == UNLOCK_ADDR) |=> !per_we);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

bind keyed_wr_gate kwg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLOCK_ADDR(UNLOCK_ADDR),
  .KEY_WORD(DATA_W'(KEY))
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .per_we(per_we), .per_addr(per_addr),
  .wr_en_o(wr_en_o), .wr_rdy_o(wr_rdy_o), .err_o(err_o)
);

// File: tb/keyed_wr_gate_tb.sv
module keyed_wr_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [7:0]  host_raddr = 8'h3C;
  logic [31:0] host_rdata;
  logic [31:0] per_rdata = '0;
  logic [7:0]  per_raddr;
  logic        per_we;
  logic [7:0]  per_addr;
  logic [31:0] per_wdata;
  logic        wr_en_o, wr_rdy_o, err_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  keyed_wr_gate u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_raddr(host_raddr),
    .host_rdata(host_rdata), .per_rdata(per_rdata), .per_raddr(per_raddr),
    .per_we(per_we), .per_addr(per_addr), .per_wdata(per_wdata),
    .wr_en_o(wr_en_o), .wr_rdy_o(wr_rdy_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] data;
    logic [1:0]  ticks;
    logic        fwd;
    logic        wen;
    logic        rdy;
    logic        err;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'h3C, 32'h0000A55A, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 arm
    '{8'h10, 32'hDEADBEEF, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 R5 R6 partial
    '{8'h3C, 32'h0000A55A, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0}, // R9 key while busy, R6 third tick
    '{8'h00, 32'h12345678, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 ctrl address
    '{8'h3C, 32'h0001A55A, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 upper bits
    '{8'h3C, 32'h0000A55A, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0}, // R2
    '{8'h3C, 32'h00001234, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 other value
    '{8'h3C, 32'h0000A55A, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0}, // R2
    '{8'h20, 32'hCAFEF00D, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 R6
    '{8'h3C, 32'h0000A55A, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R9
    '{8'h24, 32'h11112222, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1}, // R8 drop while busy
    '{8'h24, 32'h33334444, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 retry, R11
    '{8'h28, 32'h55556666, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1}  // R7 locked
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1;
    host_addr = a;
    host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 enable", 32'(wr_en_o), 32'd0);
    chk("R1 ready", 32'(wr_rdy_o), 32'd1);
    chk("R1 error", 32'(err_o), 32'd0);
    chk("R1 per_we", 32'(per_we), 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      host_write(v.addr, v.data);
      chk("R4/R7/R9 per_we", 32'(per_we), 32'(v.fwd));
      if (v.fwd) begin
        chk("R4 per_addr", 32'(per_addr), 32'(v.addr));
        chk("R4 per_wdata", per_wdata, v.data);
      end
      chk("R2/R3/R5/R8 enable bit31", 32'(host_rdata[31]), 32'(v.wen));
      chk("R7/R8/R11 error", 32'(err_o), 32'(v.err));
      @(negedge clk);
      chk("R4 pulse ends", 32'(per_we), 32'd0);
      for (int t = 0; t < int'(v.ticks); t++) begin
        slow_tick = 1'b1;
        @(negedge clk);
      end
      slow_tick = 1'b0;
      chk("R6 ready", 32'(wr_rdy_o), 32'(v.rdy));
    end

    // R10 read mux
    host_raddr = 8'h00;
    per_rdata = 32'hFFFFFF7F;
    #1;
    chk("R10 ctrl ready bit", host_rdata, 32'hFFFFFFFF);
    host_raddr = 8'h10;
    per_rdata = 32'h5A5A0080;
    #1;
    chk("R10 passthrough", host_rdata, 32'h5A5A0080);
    chk("R10 per_raddr", 32'(per_raddr), 32'h10);
    host_raddr = 8'h3C;
    #1;
    chk("R10 unlock word", host_rdata, 32'h00000001);

    // R6 ready low seen through ctrl word
    host_write(8'h3C, 32'h0000A55A);
    host_write(8'h30, 32'h0BADF00D);
    host_raddr = 8'h00;
    per_rdata = 32'h00000000;
    #1;
    chk("R6 ctrl bit7 busy", host_rdata, 32'h00000000);
    host_raddr = 8'h3C;

    // R11 error persists through good key and forwarded writes, R1 clears on reset
    chk("R11 error held", 32'(err_o), 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 error after reset", 32'(err_o), 32'd0);
    chk("R1 ready after reset", 32'(wr_rdy_o), 32'd1);
    chk("R1 enable after reset", 32'(wr_en_o), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule